// File: doc/BRIEF.md
# Cache-Line Address Monitor and Wait Unit

This unit gives one logical processor a cheap way to sleep until another agent writes to a chosen memory line. A monitor command arms the unit with an address. From then on the unit compares every snooped store address, from any number of snoop ports, against the armed line. A match sets a private event-pending flag. Software cannot read this flag. It matters only to the wait command.

A wait command puts the processor into an idle state. The processor stays there until a matching store is seen or an interrupt is raised. The unit then drops the sleep output and pulses the wake output for one cycle, together with a cause code. Every completed wait disarms the monitor, so software must issue monitor and then wait again on each pass of its polling loop.

Top module: `line_watch_idle`

## Requirements
- R1: After reset, `sleep_o` and `wake_o` are low and no line is armed.
- R2: A wait issued while a line is armed, no event is pending and `irq` is low raises `sleep_o` on the next clock edge, with no wake pulse.
- R3: While sleeping, a valid store on any snoop port whose address bits above bit log2(LINE_BYTES)-1 (above bit 5 for 64-byte lines) equal those of the armed address does two things on the next edge. It clears `sleep_o` and pulses `wake_o` for one cycle with `wake_cause_o` = 1 (store). The byte offset within the line is ignored. `wake_cause_o` is 0 whenever `wake_o` is low.
- R4: A store to a different line, or a matching address with its snoop valid low, leaves `sleep_o` high.
- R5: An asserted `irq` ends sleep on the next edge with `wake_cause_o` = 2 (interrupt). A wait issued with `irq` high and a line armed completes at once with cause 2. When a matching store and `irq` come in the same cycle, the cause is 1.
- R6: A wait issued while an event is already pending completes on the next edge with a wake pulse and cause 1, and `sleep_o` never rises.
- R7: A wait issued with no line armed completes on the next edge with a wake pulse and cause 0 (none), without sleeping.
- R8: Every wait completion disarms the monitor. A later wait without a new monitor completes as in R7.
- R9: A monitor command clears any pending event and replaces the armed line. After that, stores to the old line do not wake the processor.
- R10: Monitor and wait commands that arrive while sleeping are ignored.
- R11: When monitor and wait arrive in the same cycle, the monitor takes effect first, and the wait then sleeps on the new line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| arm_valid | input | 1 | Monitor command strobe |
| arm_addr | input | ADDR_W | Address whose line is armed |
| wait_valid | input | 1 | Wait command strobe |
| snoop_valid | input | SNOOP_PORTS | Per-port snooped store valid |
| snoop_addr | input | SNOOP_PORTS*ADDR_W | Per-port snooped store address, port i at bits [i*ADDR_W +: ADDR_W] |
| irq | input | 1 | Interrupt request (level) |
| sleep_o | output | 1 | Processor held in the idle state |
| wake_o | output | 1 | One-cycle wait-completion pulse |
| wake_cause_o | output | 2 | 0 none, 1 store, 2 interrupt; valid with `wake_o` |

## Verification
The bench builds the unit with ADDR_W = 16, LINE_BYTES = 64 and SNOOP_PORTS = 3. The narrow address makes lines next to the armed one easy to aim at: the last byte of the previous line and the first byte of the next line. Three snoop ports let the bench send matches and misses on the first, middle and last comparator lanes. A scoreboard queue holds the expected wake cause of each wait completion. Any wake pulse the bench did not predict is reported as a miscompare. So are any predicted wakes still in the queue at the end.

// File: rtl/line_watch_pkg.sv
package line_watch_pkg;

    typedef enum logic [1:0] {
        WAKE_NONE  = 2'd0,
        WAKE_STORE = 2'd1,
        WAKE_IRQ   = 2'd2
    } wake_cause_e;

endpackage

// File: rtl/line_watch_match.sv
module line_watch_match #(
    parameter int ADDR_W      = 48,
    parameter int LINE_BYTES  = 64,
    parameter int SNOOP_PORTS = 2,
    localparam int OFF_W      = $clog2(LINE_BYTES),
    localparam int TAG_W      = ADDR_W - OFF_W
) (
    input  logic                          armed,
    input  logic [TAG_W-1:0]              watch_tag,
    input  logic [SNOOP_PORTS-1:0]        snoop_valid,
    input  logic [SNOOP_PORTS*ADDR_W-1:0] snoop_addr,
    output logic                          hit
);

    logic [SNOOP_PORTS-1:0] lane_hit;

    for (genvar p = 0; p < SNOOP_PORTS; p++) begin : g_lane
        logic [ADDR_W-1:0] lane_addr;
        logic [OFF_W-1:0]  lane_ofs_unused;
        assign lane_addr       = snoop_addr[p*ADDR_W +: ADDR_W];
        assign lane_ofs_unused = lane_addr[OFF_W-1:0];
        assign lane_hit[p]     = snoop_valid[p] && (lane_addr[ADDR_W-1:OFF_W] == watch_tag);
    end

    assign hit = armed && (|lane_hit);

endmodule

// File: rtl/line_watch_ctrl.sv
module line_watch_ctrl
    import line_watch_pkg::*;
#(
    parameter int TAG_W = 42
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             arm_valid,
    input  logic [TAG_W-1:0] arm_tag,
    input  logic             wait_valid,
    input  logic             irq,
    input  logic             hit,
    output logic             armed,
    output logic [TAG_W-1:0] watch_tag,
    output logic             sleep,
    output logic             wake,
    output wake_cause_e      cause
);

    typedef struct packed {
        logic             armed;
        logic [TAG_W-1:0] tag;
        logic             pend;
        logic             sleep;
        logic             wake;
        wake_cause_e      cause;
    } ctrl_state_t;

    ctrl_state_t st_d, st_q;

    always_comb begin
        logic             pend_now;
        logic             armed_v;
        logic [TAG_W-1:0] tag_v;
        logic             pend_v;
        logic             finish;
        wake_cause_e      why;

        st_d       = st_q;
        st_d.wake  = 1'b0;
        st_d.cause = WAKE_NONE;
        pend_now   = st_q.pend || hit;
        finish     = 1'b0;
        why        = WAKE_NONE;
        armed_v    = st_q.armed;
        tag_v      = st_q.tag;
        pend_v     = pend_now;

        if (st_q.sleep) begin
            // Commands are ignored while asleep; only events end the state.
            if (pend_now) begin
                finish = 1'b1;
                why    = WAKE_STORE;
            end else if (irq) begin
                finish = 1'b1;
                why    = WAKE_IRQ;
            end else begin
                st_d.pend = pend_now;
            end
        end else begin
            // A monitor command acts before a wait in the same cycle.
            if (arm_valid) begin
                armed_v = 1'b1;
                tag_v   = arm_tag;
                pend_v  = 1'b0;
            end
            st_d.armed = armed_v;
            st_d.tag   = tag_v;
            st_d.pend  = pend_v;
            if (wait_valid) begin
                if (!armed_v) begin
                    finish = 1'b1;
                    why    = WAKE_NONE;
                end else if (pend_v) begin
                    finish = 1'b1;
                    why    = WAKE_STORE;
                end else if (irq) begin
                    finish = 1'b1;
                    why    = WAKE_IRQ;
                end else begin
                    st_d.sleep = 1'b1;
                end
            end
        end

        if (finish) begin
            st_d.sleep = 1'b0;
            st_d.wake  = 1'b1;
            st_d.cause = why;
            st_d.armed = 1'b0;
            st_d.pend  = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign armed     = st_q.armed;
    assign watch_tag = st_q.tag;
    assign sleep     = st_q.sleep;
    assign wake      = st_q.wake;
    assign cause     = st_q.cause;

endmodule

// File: rtl/line_watch_idle.sv
module line_watch_idle
    import line_watch_pkg::*;
#(
    parameter int ADDR_W      = 48,
    parameter int LINE_BYTES  = 64,
    parameter int SNOOP_PORTS = 2
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          arm_valid,
    input  logic [ADDR_W-1:0]             arm_addr,
    input  logic                          wait_valid,
    input  logic [SNOOP_PORTS-1:0]        snoop_valid,
    input  logic [SNOOP_PORTS*ADDR_W-1:0] snoop_addr,
    input  logic                          irq,
    output logic                          sleep_o,
    output logic                          wake_o,
    output logic [1:0]                    wake_cause_o
);

    localparam int OFF_W = $clog2(LINE_BYTES);
    localparam int TAG_W = ADDR_W - OFF_W;

    logic             armed_w;
    logic [TAG_W-1:0] tag_w;
    logic             hit_w;
    wake_cause_e      cause_w;
    logic [OFF_W-1:0] arm_ofs_unused;

    assign arm_ofs_unused = arm_addr[OFF_W-1:0];

    line_watch_match #(
        .ADDR_W      (ADDR_W),
        .LINE_BYTES  (LINE_BYTES),
        .SNOOP_PORTS (SNOOP_PORTS)
    ) i_match (
        .armed       (armed_w),
        .watch_tag   (tag_w),
        .snoop_valid (snoop_valid),
        .snoop_addr  (snoop_addr),
        .hit         (hit_w)
    );

    line_watch_ctrl #(
        .TAG_W (TAG_W)
    ) i_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .arm_valid  (arm_valid),
        .arm_tag    (arm_addr[ADDR_W-1:OFF_W]),
        .wait_valid (wait_valid),
        .irq        (irq),
        .hit        (hit_w),
        .armed      (armed_w),
        .watch_tag  (tag_w),
        .sleep      (sleep_o),
        .wake       (wake_o),
        .cause      (cause_w)
    );

    assign wake_cause_o = cause_w;

endmodule

// File: rtl/line_watch_idle_chk.sv
module line_watch_idle_chk #(
    parameter int SNOOP_PORTS = 2
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   wait_valid,
    input logic [SNOOP_PORTS-1:0] snoop_valid,
    input logic                   irq,
    input logic                   sleep_o,
    input logic                   wake_o,
    input logic [1:0]             wake_cause_o,
    input logic                   armed
);

    AST_WAKE_NOT_ASLEEP: assert property (@(posedge clk) disable iff (!rst_n)
        wake_o |-> !sleep_o); // R3

    AST_CAUSE_ONLY_ON_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
        !wake_o |-> (wake_cause_o == 2'd0)); // R3

    AST_QUIET_SLEEP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (sleep_o && !irq && (snoop_valid == '0)) |=> sleep_o); // R4

    AST_IRQ_ENDS_SLEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (sleep_o && irq) |=> (wake_o && !sleep_o)); // R5

    AST_SLEEP_EXIT_WAKES: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sleep_o) |-> wake_o); // R5

    AST_WAKE_DISARMS: assert property (@(posedge clk) disable iff (!rst_n)
        wake_o |-> !armed); // R8

    AST_SLEEP_NEEDS_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sleep_o) |-> $past(wait_valid)); // R2

    AST_SLEEP_NEEDS_ARM: assert property (@(posedge clk) disable iff (!rst_n)
        sleep_o |-> armed); // R2

endmodule

bind line_watch_idle line_watch_idle_chk #(
    .SNOOP_PORTS (SNOOP_PORTS)
) i_line_watch_idle_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .wait_valid   (wait_valid),
    .snoop_valid  (snoop_valid),
    .irq          (irq),
    .sleep_o      (sleep_o),
    .wake_o       (wake_o),
    .wake_cause_o (wake_cause_o),
    .armed        (armed_w)
);

// File: tb/test_line_watch_idle.sv
`timescale 1ns/1ps
module test_line_watch_idle;

    localparam int AW = 16;
    localparam int NP = 3;
    localparam logic [1:0] C_NONE  = 2'd0;
    localparam logic [1:0] C_STORE = 2'd1;
    localparam logic [1:0] C_IRQ   = 2'd2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          arm_valid = 1'b0;
    logic [AW-1:0] arm_addr = '0;
    logic          wait_valid = 1'b0;
    logic [NP-1:0] snoop_valid = '0;
    logic [NP*AW-1:0] snoop_addr = '0;
    logic          irq = 1'b0;
    logic          sleep_o;
    logic          wake_o;
    logic [1:0]    wake_cause_o;

    int vectors = 0;
    int miscompares = 0;
    bit done = 1'b0;

    logic [1:0] exp_q[$];
    string      tag_q[$];

    always #5 clk = ~clk;

    line_watch_idle #(
        .ADDR_W      (AW),
        .LINE_BYTES  (64),
        .SNOOP_PORTS (NP)
    ) i_line_watch_idle (
        .clk          (clk),
        .rst_n        (rst_n),
        .arm_valid    (arm_valid),
        .arm_addr     (arm_addr),
        .wait_valid   (wait_valid),
        .snoop_valid  (snoop_valid),
        .snoop_addr   (snoop_addr),
        .irq          (irq),
        .sleep_o      (sleep_o),
        .wake_o       (wake_o),
        .wake_cause_o (wake_cause_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic expect_wake(input logic [1:0] c, input string req);
        exp_q.push_back(c);
        tag_q.push_back(req);
    endtask

    // Hold the staged inputs for one clock, then clear them at the next negedge.
    task automatic step();
        @(negedge clk);
        arm_valid   = 1'b0;
        wait_valid  = 1'b0;
        snoop_valid = '0;
        snoop_addr  = '0;
        irq         = 1'b0;
    endtask

    task automatic do_arm(input logic [AW-1:0] a);
        arm_valid = 1'b1;
        arm_addr  = a;
        step();
    endtask

    task automatic do_wait();
        wait_valid = 1'b1;
        step();
    endtask

    task automatic stage_snoop(input int p, input logic [AW-1:0] a, input logic v);
        snoop_valid[p]          = v;
        snoop_addr[p*AW +: AW]  = a;
    endtask

    // Scoreboard monitor: every wake pulse must match the head of the queue.
    always @(negedge clk) begin
        if (rst_n && wake_o) begin
            vectors++;
            if (exp_q.size() == 0) begin
                miscompares++;
                $display("FAIL R3/R8: actual unexpected wake cause %0d expected no wake", wake_cause_o);
            end else begin
                logic [1:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if (wake_cause_o !== e) begin
                    miscompares++;
                    $display("FAIL %s: actual cause %0d expected %0d", t, wake_cause_o, e);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 sleep in reset", sleep_o, 1'b0);
        chk("R1 wake in reset", wake_o, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 sleep after reset", sleep_o, 1'b0);

        // R7: wait with nothing armed completes at once
        expect_wake(C_NONE, "R7");
        do_wait();
        chk("R7 no sleep when unarmed", sleep_o, 1'b0);
        chk("R7 wake pulse", wake_o, 1'b1);

        // R2 then R3 with offset inside the line on the last snoop lane
        do_arm(16'h1240);
        do_wait();
        chk("R2 sleep entered", sleep_o, 1'b1);
        chk("R2 no wake on entry", wake_o, 1'b0);
        repeat (3) step();
        chk("R2 sleep held", sleep_o, 1'b1);
        expect_wake(C_STORE, "R3");
        stage_snoop(2, 16'h127F, 1'b1);
        step();
        chk("R3 store wakes", sleep_o, 1'b0);

        // R8: the previous wake disarmed the monitor
        expect_wake(C_NONE, "R8");
        do_wait();
        chk("R8 no sleep after disarm", sleep_o, 1'b0);

        // R4: misses keep sleeping, then R5 interrupt wakes
        do_arm(16'h2000);
        do_wait();
        stage_snoop(0, 16'h2040, 1'b1);
        step();
        chk("R4 next line ignored", sleep_o, 1'b1);
        stage_snoop(1, 16'h1FFF, 1'b1);
        step();
        chk("R4 previous line ignored", sleep_o, 1'b1);
        stage_snoop(0, 16'h2000, 1'b0);
        step();
        chk("R4 invalid snoop ignored", sleep_o, 1'b1);
        expect_wake(C_IRQ, "R5");
        irq = 1'b1;
        step();
        chk("R5 interrupt wakes", sleep_o, 1'b0);

        // R5 priority: store and interrupt together report store
        do_arm(16'h3000);
        do_wait();
        expect_wake(C_STORE, "R5 priority");
        stage_snoop(1, 16'h3010, 1'b1);
        irq = 1'b1;
        step();
        chk("R5 joint wake", sleep_o, 1'b0);

        // R6: pending already set when the wait comes
        do_arm(16'h4000);
        stage_snoop(0, 16'h4008, 1'b1);
        step();
        expect_wake(C_STORE, "R6");
        do_wait();
        chk("R6 no sleep with pending event", sleep_o, 1'b0);

        // R9: re-arm clears pending and moves the line
        do_arm(16'h5000);
        stage_snoop(2, 16'h5000, 1'b1);
        step();
        do_arm(16'h6000);
        do_wait();
        chk("R9 pending cleared by re-arm", sleep_o, 1'b1);
        stage_snoop(0, 16'h5000, 1'b1);
        step();
        chk("R9 old line ignored", sleep_o, 1'b1);
        expect_wake(C_STORE, "R9");
        stage_snoop(1, 16'h6020, 1'b1);
        step();
        chk("R9 new line wakes", sleep_o, 1'b0);

        // R10: commands while asleep are ignored
        do_arm(16'h7000);
        do_wait();
        do_arm(16'h8000);
        do_wait();
        chk("R10 still asleep", sleep_o, 1'b1);
        stage_snoop(2, 16'h8000, 1'b1);
        step();
        chk("R10 ignored arm left old line", sleep_o, 1'b1);
        expect_wake(C_STORE, "R10");
        stage_snoop(0, 16'h7000, 1'b1);
        step();
        chk("R10 old line wakes", sleep_o, 1'b0);

        // R11: arm and wait in the same cycle
        arm_valid = 1'b1;
        arm_addr  = 16'h9000;
        wait_valid = 1'b1;
        step();
        chk("R11 sleeps on new line", sleep_o, 1'b1);
        expect_wake(C_IRQ, "R11");
        irq = 1'b1;
        step();
        chk("R11 wake", sleep_o, 1'b0);

        // R5: wait issued with interrupt already high
        do_arm(16'hA000);
        expect_wake(C_IRQ, "R5 wait with irq");
        wait_valid = 1'b1;
        irq = 1'b1;
        step();
        chk("R5 no sleep with irq", sleep_o, 1'b0);

        repeat (4) step();
        chk("R3 all expected wakes seen", exp_q.size(), 0);

        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule